// File: doc/BRIEF.md
# Windowed Survivor Traceback Memory

This block holds the survivor decisions of a 64-state Viterbi decoder and turns them into decoded bits. Every accepted symbol delivers one word of decision bits, one bit per trellis state, which is stored in one of three 16-word memory units. The units take turns: one fills with new words, one holds the newest complete block and serves as convergence depth, and one holds the block that is decoded.

When a block of 16 words is complete and an older block is already stored, a traceback starts from state 0. It walks the newest block from its last word back to its first, and then walks the older block the same way. Only the second walk produces output. The decoded bits are collected by address and leave one per clock in storage order. Read data passes through a holding register in each unit and one pipeline register before it reaches the state update. The three holding registers together form a 192-bit decision bus.

Top module: `survivor_traceback`

## Requirements
- R1: While rst_n is low and after it is released, bit_valid is 0. A partly filled block is discarded by reset, and the next word goes to address 0 of unit 0. No bits come out until two full blocks have been stored since reset.
- R2: Each cycle with dec_valid high stores dec_word at the next address of the current unit, from address 0 to 15. After address 15 the next unit is filled, in the order 0, 1, 2, 0.
- R3: When the 16th word of a block is stored and an earlier block exists, a traceback starts from state 0. It covers the newest block from address 15 down to 0, then the previous block from address 15 down to 0.
- R4: One traceback step with state s (6 bits) reads d = word[s], where bit index s selects the state's bit. The next state is {s[4:0], d}, and the decoded bit is s[5] before the step.
- R5: The 16 steps over the newest block are convergence only and produce no output bits.
- R6: Each decoded block leaves as a run of exactly 16 consecutive cycles with bit_valid high. The bit from address 0 comes first and the bit from address 15 comes last.
- R7: bit_valid first goes high in the cycle that follows the 35th rising edge after the edge that stores the block's final word.
- R8: dec_valid is high at most once in any three consecutive cycles. Under that rule the unit being read never equals the unit being written, and a new traceback never starts while one is still in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | dec_word is to be stored this cycle |
| dec_word | input | 64 | Decision bits, bit i belongs to state i |
| bit_valid | output | 1 | bit_out carries a decoded bit |
| bit_out | output | 1 | Decoded bit |

## Verification
The decoded bits of a block are due 35 rising edges after the edge that stores that block's final word, and then come out for 16 cycles. This delay counts one read edge, one pipeline edge, the state-update edges of 32 steps and the output load. The bench counts negative edges from that storing edge to the first high bit_valid and expects 35. All other result checks use a monitor that samples bit_valid and bit_out on the falling edge. Blocks are spaced so that each run is finished long before the next one is due, so every check compares whole runs in order and none depends on one exact edge.

// File: rtl/survivor_traceback.sv
module survivor_traceback #(
  parameter int ST_BITS = 6,
  parameter int BLK_LEN = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [(1<<ST_BITS)-1:0]  dec_word,
  output logic                     bit_valid,
  output logic                     bit_out
);
  localparam int NST   = 1 << ST_BITS;
  localparam int AW    = $clog2(BLK_LEN);
  localparam int UNITS = 3;
  localparam logic [AW-1:0] LAST    = AW'(BLK_LEN - 1);
  localparam logic [AW:0]   TB_LAST = (AW+1)'(2 * BLK_LEN - 1);

  logic [1:0]          wr_bank, cbank, dbank, rd_bank, s1_bank;
  logic [AW-1:0]       wr_addr, rd_addr, s1_addr, s2_addr;
  logic                primed, tb_act, s1_v, s1_dec, s2_v, s2_dec, done;
  logic [AW:0]         tb_cnt, out_left;
  logic [UNITS*NST-1:0] dbus;
  logic [NST-1:0]      pipe;
  logic [ST_BITS-1:0]  st;
  logic [BLK_LEN-1:0]  obuf, out_sr;
  logic                blk_end, tb_start;

  assign blk_end  = dec_valid && (wr_addr == LAST);
  assign tb_start = blk_end && primed;
  assign rd_addr  = LAST - tb_cnt[AW-1:0];
  assign rd_bank  = tb_cnt[AW] ? dbank : cbank;

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    logic [NST-1:0] m [BLK_LEN];
    logic [NST-1:0] q;
    always_ff @(posedge clk) begin
      if (dec_valid && wr_bank == 2'(g)) m[wr_addr] <= dec_word;
      if (tb_act && rd_bank == 2'(g)) q <= m[rd_addr];
    end
    assign dbus[g*NST +: NST] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_bank <= '0;
      wr_addr <= '0;
      primed  <= 1'b0;
    end else if (dec_valid) begin
      wr_addr <= wr_addr + 1'b1;
      if (blk_end) begin
        wr_bank <= (wr_bank == 2'd2) ? 2'd0 : wr_bank + 2'd1;
        primed  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_act <= 1'b0;
      tb_cnt <= '0;
      cbank  <= '0;
      dbank  <= '0;
    end else if (tb_start) begin
      tb_act <= 1'b1;
      tb_cnt <= '0;
      cbank  <= wr_bank;
      dbank  <= (wr_bank == 2'd0) ? 2'd2 : wr_bank - 2'd1;
    end else if (tb_act) begin
      tb_cnt <= tb_cnt + 1'b1;
      if (tb_cnt == TB_LAST) tb_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    s1_bank <= rd_bank;
    s1_addr <= rd_addr;
    s1_dec  <= tb_cnt[AW];
    pipe    <= dbus[s1_bank*NST +: NST];
    s2_addr <= s1_addr;
    s2_dec  <= s1_dec;
    if (s2_v && s2_dec) obuf[s2_addr] <= st[ST_BITS-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s2_v     <= 1'b0;
      st       <= '0;
      done     <= 1'b0;
      out_sr   <= '0;
      out_left <= '0;
    end else begin
      s1_v <= tb_act;
      s2_v <= s1_v;
      done <= s2_v && s2_dec && (s2_addr == '0);
      if (tb_start) st <= '0;
      else if (s2_v) st <= {st[ST_BITS-2:0], pipe[st]};
      if (done) begin
        out_sr   <= obuf;
        out_left <= (AW+1)'(BLK_LEN);
      end else if (out_left != '0) begin
        out_sr   <= out_sr >> 1;
        out_left <= out_left - 1'b1;
      end
    end
  end

  assign bit_valid = (out_left != '0);
  assign bit_out   = out_sr[0];

  // R8
  in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (!$past(dec_valid) && !$past(dec_valid, 2)));
  // R8
  rd_wr_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_act |-> (rd_bank != wr_bank));
  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_start |-> (!tb_act && !s1_v && !s2_v));
  // R6
  drained_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bit_valid);
  // R5
  conv_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !s2_dec) |=> !done);
endmodule

// File: tb/survivor_traceback_tb.sv
module survivor_traceback_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic [63:0] dec_word = '0;
  logic bit_valid, bit_out;

  always #2.5 clk = ~clk;

  survivor_traceback u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_word(dec_word),
    .bit_valid(bit_valid), .bit_out(bit_out)
  );

  localparam logic [63:0] PAT [8] = '{
    64'h0123_4567_89AB_CDEF, 64'hF0F0_0F0F_3C3C_C3C3, 64'hDEAD_BEEF_0BAD_F00D,
    64'h5555_AAAA_3333_CCCC, 64'h8000_0001_7FFF_FFFE, 64'h1F2E_3D4C_5B6A_7988,
    64'hFFFF_0000_FF00_00FF, 64'h9249_2492_4924_9249};
  localparam int GAP [8] = '{3, 4, 3, 6, 3, 5, 3, 7};

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [63:0] bm [3][16];
  int wb = 0, wa = 0, pb = 0;
  bit primed = 0;
  logic obs [512];
  logic expb [512];
  int obs_n = 0, exp_n = 0;
  int run_len = 0, runs_seen = 0, bad_runs = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rotl(logic [63:0] v, int n);
    int k = n % 64;
    return (k == 0) ? v : ((v << k) | (v >> (64 - k)));
  endfunction

  function automatic logic [15:0] ref_trace(int cb, int db);
    logic [5:0] s = '0;
    logic [15:0] r = '0;
    logic d;
    for (int a = 15; a >= 0; a--) begin
      d = bm[cb][a][s];
      s = {s[4:0], d};
    end
    for (int a = 15; a >= 0; a--) begin
      d = bm[db][a][s];
      r[a] = s[5];
      s = {s[4:0], d};
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) run_len = 0;
    else if (bit_valid) begin
      obs[obs_n] = bit_out;
      obs_n++;
      run_len++;
    end else if (run_len != 0) begin
      runs_seen++;
      if (run_len != 16) bad_runs++;
      run_len = 0;
    end
  end

  task automatic model_put(logic [63:0] w);
    logic [15:0] r;
    bm[wb][wa] = w;
    wa++;
    if (wa == 16) begin
      wa = 0;
      if (primed) begin
        r = ref_trace(wb, pb);
        for (int j = 0; j < 16; j++) begin
          expb[exp_n] = r[j];
          exp_n++;
        end
      end
      pb = wb;
      wb = (wb + 1) % 3;
      primed = 1;
    end
  endtask

  task automatic send_word(logic [63:0] w);
    @(negedge clk);
    dec_valid = 1'b1;
    dec_word = w;
    model_put(w);
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic send_block(int b, int gap, int mode);
    for (int i = 0; i < 16; i++) begin
      if (mode == 0) send_word('0);
      else if (mode == 1) send_word('1);
      else send_word(rotl(PAT[(b + i) % 8], i * 5) ^ 64'(b * 97 + i));
      repeat (gap - 2) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wb = 0; wa = 0; pb = 0; primed = 0;
    obs_n = 0; exp_n = 0;
  endtask

  task automatic wait_bits(int target);
    int t = 0;
    while (obs_n < target && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] obs_vec(int base);
    logic [15:0] v;
    for (int j = 0; j < 16; j++) v[j] = obs[base + j];
    return v;
  endfunction

  function automatic logic [15:0] exp_vec(int base);
    logic [15:0] v;
    for (int j = 0; j < 16; j++) v[j] = expb[base + j];
    return v;
  endfunction

  initial begin
    int n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 bit_valid during reset", 64'(bit_valid), 0);
    do_reset();
    chk("R1 bit_valid after reset", 64'(bit_valid), 0);

    // R5: a single block produces nothing
    send_block(0, 3, 0);
    repeat (60) @(negedge clk);
    chk("R1 R5 no output after one block", 64'(obs_n), 0);

    // R7 latency and R4/R6 known pattern
    for (int i = 0; i < 15; i++) begin
      send_word('1);
      @(negedge clk);
    end
    send_word('1);
    n = 0;
    while (!bit_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R7 latency", 64'(n), 35);
    wait_bits(16);
    chk("R4 R6 ones over zeros", 64'(obs_vec(0)), 64'h0000_FC00);

    // R1: partial block discarded by reset
    do_reset();
    for (int i = 0; i < 10; i++) begin
      send_word('0);
      @(negedge clk);
    end
    do_reset();
    chk("R1 bit_valid after mid-block reset", 64'(bit_valid), 0);
    send_block(0, 3, 1);
    send_block(0, 3, 0);
    wait_bits(16);
    chk("R1 R4 zeros over ones", 64'(obs_vec(0)), 64'h0000_03FF);

    // R2 R3 R4 R8: table walk across unit rotation
    do_reset();
    for (int b = 0; b < 8; b++) send_block(b, GAP[b], 2);
    wait_bits(7 * 16);
    chk("R3 blocks decoded", 64'(obs_n), 64'(exp_n));
    for (int k = 0; k < 7; k++)
      chk($sformatf("R2 R3 R4 R8 block %0d", k), 64'(obs_vec(16 * k)), 64'(exp_vec(16 * k)));

    repeat (5) @(negedge clk);
    chk("R6 runs of 16", 64'(bad_runs), 0);
    chk("R6 run count", 64'(runs_seen), 9);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule